// File: doc/BRIEF.md
# Time-Gain Compensation Step Generator

This block drives the control code of a variable-gain amplifier's DAC while an acquisition line is being recorded. The host loads a small table with one gain code per time segment. A line-start pulse sets the output to the first entry and begins a segment timer that counts sample ticks. Each time a segment's worth of ticks has passed, the output moves to the next entry. After the last segment the output keeps its final code and the block goes idle until the next line-start pulse.

With the default parameters the table has 32 entries of 10 bits (codes 0 to 1023). One segment is 512 sample ticks, which is 8 µs at a 64 MHz tick rate, so 32 segments cover a 256 µs line. At reset the table is filled with default contents, either a flat code or a saturating ramp; a parameter selects which. Between lines, a readback output follows the DAC code. During a line that readback stays frozen at the level that was present before the line began.

Top module: `tgc_step_gen`

## Requirements
- R1: After reset, dac_code, rb_level and line_active are 0. Table entry i holds FLAT_CODE when USE_RAMP is 0, or min(i*RAMP_STEP, 2^CODE_W-1) when USE_RAMP is 1.
- R2: In the cycle after line_start is high, line_active is 1 and dac_code equals table entry 0.
- R3: While a line runs, only cycles with tick high are counted. After every TICKS_PER_SEG counted ticks the index moves up by one, and dac_code shows the new entry in the cycle after the last counted tick of the segment.
- R4: When the last segment (index ENTRIES-1) has counted TICKS_PER_SEG ticks, line_active falls in the next cycle and dac_code keeps the last entry.
- R5: A line_start pulse during a running line restarts the line at index 0 with a fresh tick count.
- R6: When wr_en is high while line_active and line_start are both low, wr_data is stored at entry wr_addr and used by later lines.
- R7: A write is dropped when wr_en is high while line_active is high or in the same cycle as line_start.
- R8: While line_active is low, rb_level equals dac_code. While a line runs, rb_level holds the dac_code value from before the line began.
- R9: dac_code changes only on a line start or on a segment advance. It is stable outside lines and on cycles without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample-tick enable that drives the segment timer |
| line_start | input | 1 | One-cycle pulse that begins an acquisition line |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | $clog2(ENTRIES) | Table entry to write |
| wr_data | input | CODE_W | Gain code to store |
| dac_code | output | CODE_W | Gain code driven to the amplifier DAC |
| line_active | output | 1 | High while a line is being stepped |
| rb_level | output | CODE_W | Readback of the DAC level |

## Verification
The bench builds the block with 16 entries, 5 ticks per segment and the ramp default at a step of 70. This makes each line short, so hundreds of full lines, restarts and dropped writes fit in the run. With a step of 70 the top ramp entries exceed 1023, so the saturation of the defaults is reached. Random tick gating adds stalls in the middle of segments, and the directed cases cover a write in the same cycle as a line start, a write in the middle of a line, and a restart.

// File: rtl/tgc_pkg.sv
package tgc_pkg;
   // Saturating ramp used for the reset contents of the gain table
   function automatic int unsigned sat_ramp(input int unsigned idx,
                                            input int unsigned step,
                                            input int unsigned maxc);
      int unsigned v;
      v = idx * step;
      return (v > maxc) ? maxc : v;
   endfunction
endpackage

// File: rtl/tgc_table.sv
module tgc_table #(
   parameter int unsigned ENTRIES   = 32,
   parameter int unsigned CODE_W    = 10,
   parameter bit          USE_RAMP  = 1'b0,
   parameter int unsigned RAMP_STEP = 32,
   parameter int unsigned FLAT_CODE = 512,
   localparam int unsigned IDX_W    = $clog2(ENTRIES),
   localparam int unsigned MAX_CODE = (1 << CODE_W) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [CODE_W-1:0] wdata,
   input  logic [IDX_W-1:0]  raddr,
   output logic [CODE_W-1:0] rdata
);
   logic [CODE_W-1:0] mem_q [ENTRIES];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      localparam int unsigned RAMP_V = tgc_pkg::sat_ramp(i, RAMP_STEP, MAX_CODE);
      localparam int unsigned INIT_V = USE_RAMP ? RAMP_V : FLAT_CODE;
      always_ff @(posedge clk) begin
         if (!rst_n)
            mem_q[i] <= CODE_W'(INIT_V);
         else if (we && (waddr == IDX_W'(i)))
            mem_q[i] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < ENTRIES; k++)
         if (raddr == IDX_W'(k)) rdata = mem_q[k];
   end
endmodule

// File: rtl/tgc_seq.sv
module tgc_seq #(
   parameter int unsigned ENTRIES       = 32,
   parameter int unsigned TICKS_PER_SEG = 512,
   localparam int unsigned IDX_W        = $clog2(ENTRIES),
   localparam int unsigned CNT_W        = $clog2(TICKS_PER_SEG),
   localparam int unsigned LAST_IDX     = ENTRIES - 1,
   localparam int unsigned LAST_CNT     = TICKS_PER_SEG - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             line_start,
   output logic             active,
   output logic             ld,
   output logic [IDX_W-1:0] ld_idx
);
   logic [IDX_W-1:0] idx_q;
   logic [CNT_W-1:0] cnt_q;
   logic             act_q;
   logic             seg_end;
   logic             last_seg;

   assign seg_end  = act_q && tick && (cnt_q == CNT_W'(LAST_CNT));
   assign last_seg = (idx_q == IDX_W'(LAST_IDX));
   assign active   = act_q;

   always_comb begin
      ld     = line_start || (seg_end && !last_seg);
      ld_idx = line_start ? '0 : idx_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         idx_q <= '0;
         cnt_q <= '0;
      end else if (line_start) begin
         act_q <= 1'b1;
         idx_q <= '0;
         cnt_q <= '0;
      end else if (act_q && tick) begin
         if (seg_end) begin
            cnt_q <= '0;
            if (last_seg) act_q <= 1'b0;
            else          idx_q <= idx_q + 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/tgc_step_gen.sv
module tgc_step_gen #(
   parameter int unsigned ENTRIES       = 32,
   parameter int unsigned CODE_W        = 10,
   parameter int unsigned TICKS_PER_SEG = 512,
   parameter bit          USE_RAMP      = 1'b0,
   parameter int unsigned RAMP_STEP     = 32,
   parameter int unsigned FLAT_CODE     = 512,
   localparam int unsigned IDX_W        = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              line_start,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_addr,
   input  logic [CODE_W-1:0] wr_data,
   output logic [CODE_W-1:0] dac_code,
   output logic              line_active,
   output logic [CODE_W-1:0] rb_level
);
   if (ENTRIES < 2) begin : g_bad_entries
      $error("tgc_step_gen: ENTRIES must be at least 2");
   end
   if (TICKS_PER_SEG < 2) begin : g_bad_ticks
      $error("tgc_step_gen: TICKS_PER_SEG must be at least 2");
   end
   if (CODE_W < 1 || CODE_W > 16) begin : g_bad_width
      $error("tgc_step_gen: CODE_W out of range");
   end
   if (!USE_RAMP && FLAT_CODE >= (1 << CODE_W)) begin : g_bad_flat
      $error("tgc_step_gen: FLAT_CODE does not fit CODE_W");
   end

   logic              ld;
   logic [IDX_W-1:0]  ld_idx;
   logic [CODE_W-1:0] rd_code;
   logic              wr_ok;
   logic [CODE_W-1:0] dac_q;
   logic [CODE_W-1:0] held_q;

   assign wr_ok = wr_en && !line_active && !line_start;

   tgc_seq #(
      .ENTRIES       (ENTRIES),
      .TICKS_PER_SEG (TICKS_PER_SEG)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .line_start (line_start),
      .active     (line_active),
      .ld         (ld),
      .ld_idx     (ld_idx)
   );

   tgc_table #(
      .ENTRIES   (ENTRIES),
      .CODE_W    (CODE_W),
      .USE_RAMP  (USE_RAMP),
      .RAMP_STEP (RAMP_STEP),
      .FLAT_CODE (FLAT_CODE)
   ) u_tbl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_ok),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (ld_idx),
      .rdata (rd_code)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dac_q  <= '0;
         held_q <= '0;
      end else begin
         if (ld) dac_q <= rd_code;
         if (line_start && !line_active) held_q <= dac_q;
      end
   end

   assign dac_code = dac_q;
   assign rb_level = line_active ? held_q : dac_q;
endmodule

// File: rtl/tgc_step_gen_chk.sv
module tgc_step_gen_chk #(
   parameter int unsigned CODE_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              line_start,
   input logic [CODE_W-1:0] dac_code,
   input logic              line_active,
   input logic [CODE_W-1:0] rb_level
);
   p_start_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |=> line_active);

   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_active && !line_start) |=> $stable(dac_code));

   p_notick_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (line_active && !tick && !line_start) |=> $stable(dac_code));

   p_end_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(line_active) |-> $stable(dac_code));

   p_rb_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (line_active && $past(line_active)) |-> $stable(rb_level));
endmodule

bind tgc_step_gen tgc_step_gen_chk #(.CODE_W(CODE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick        (tick),
   .line_start  (line_start),
   .dac_code    (dac_code),
   .line_active (line_active),
   .rb_level    (rb_level)
);

// File: tb/tgc_step_gen_test.sv
`timescale 1ns/1ps
module tgc_step_gen_test;
   localparam int unsigned E  = 16;
   localparam int unsigned T  = 5;
   localparam int unsigned CW = 10;
   localparam int unsigned ST = 70;
   localparam int unsigned IW = $clog2(E);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          line_start = 1'b0;
   logic          wr_en = 1'b0;
   logic [IW-1:0] wr_addr = '0;
   logic [CW-1:0] wr_data = '0;
   logic [CW-1:0] dac_code;
   logic          line_active;
   logic [CW-1:0] rb_level;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [CW-1:0] m_tbl [E];
   logic [CW-1:0] m_code, m_held;
   logic          m_act;
   int            m_idx, m_cnt;

   always #2.5 clk = ~clk;

   tgc_step_gen #(
      .ENTRIES(E), .CODE_W(CW), .TICKS_PER_SEG(T),
      .USE_RAMP(1'b1), .RAMP_STEP(ST), .FLAT_CODE(512)
   ) uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .line_start(line_start),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .dac_code(dac_code), .line_active(line_active), .rb_level(rb_level)
   );

   function automatic int dflt(input int i);
      int v = i * ST;
      return (v > 1023) ? 1023 : v;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cyc(input logic ls, input logic tk, input logic we,
                      input int wa, input int wd);
      string tg;
      @(negedge clk);
      line_start = ls; tick = tk; wr_en = we;
      wr_addr = IW'(wa); wr_data = CW'(wd);
      @(posedge clk);
      tg = "R9";
      if (we && !m_act && !ls) m_tbl[wa] = CW'(wd);
      if (ls) begin
         tg = m_act ? "R5" : "R2";
         if (!m_act) m_held = m_code;
         m_code = m_tbl[0]; m_act = 1'b1; m_idx = 0; m_cnt = 0;
      end else if (m_act && tk) begin
         if (m_cnt == T - 1) begin
            m_cnt = 0;
            if (m_idx == E - 1) begin
               m_act = 1'b0; tg = "R4";
            end else begin
               m_idx++; m_code = m_tbl[m_idx]; tg = "R3";
            end
         end else m_cnt++;
      end
      #1;
      chk(tg, dac_code, m_code);
      chk(tg, line_active, m_act);
      chk("R8", rb_level, m_act ? m_held : m_code);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, 1'b0, 0, 0);
   endtask

   initial begin
      #900000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      for (int i = 0; i < E; i++) m_tbl[i] = CW'(dflt(i));
      m_code = '0; m_held = '0; m_act = 1'b0; m_idx = 0; m_cnt = 0;
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      chk("R1 dac", dac_code, 0);
      chk("R1 active", line_active, 0);
      chk("R1 rb", rb_level, 0);

      // R1/R2/R3/R4: full line on defaults, tick every cycle
      cyc(1'b1, 1'b1, 1'b0, 0, 0);
      chk("R2 entry0", dac_code, dflt(0));
      ticks(T);
      chk("R3 entry1", dac_code, dflt(1));
      ticks((E - 1) * T);
      chk("R4 idle", line_active, 0);
      chk("R4 last kept", dac_code, dflt(E - 1));
      chk("R1 saturated", dac_code, 1023);
      ticks(10);
      chk("R9 hold", dac_code, 1023);

      // R6: idle write used by next line
      cyc(1'b0, 1'b0, 1'b1, 3, 777);
      cyc(1'b1, 1'b1, 1'b0, 0, 0);
      chk("R8 frozen", rb_level, 1023);
      ticks(3 * T);
      chk("R6 written entry", dac_code, 777);
      // R7: write during line dropped
      cyc(1'b0, 1'b1, 1'b1, 5, 111);
      ticks(E * T);
      cyc(1'b1, 1'b0, 1'b1, 0, 999);  // R7 write with line_start
      chk("R7 start write dropped", dac_code, dflt(0));
      ticks(5 * T);
      chk("R7 mid-line write dropped", dac_code, dflt(5));
      // R5: restart mid-line
      cyc(1'b1, 1'b1, 1'b0, 0, 0);
      chk("R5 restart", dac_code, dflt(0));
      ticks(T - 1);
      chk("R5 fresh count", dac_code, dflt(0));
      ticks(1);
      chk("R5 advance", dac_code, dflt(1));
      ticks(E * T);

      // random mix
      for (int n = 0; n < 25000; n++) begin
         logic ls, tk, we;
         ls = ($urandom_range(0, 199) == 0);
         tk = ($urandom_range(0, 9) < 7);
         we = ($urandom_range(0, 3) == 0);
         cyc(ls, tk, we, $urandom_range(0, E - 1), $urandom_range(0, 1023));
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule